// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of an 8-bit accumulator datapath. Each clock it takes an operation selector, the accumulator, a second byte operand, the current flag byte and two 16-bit register pairs. One clock later it presents the byte result, an updated flag byte and a 16-bit pair sum. The flag byte holds sign, zero, auxiliary (half) carry, even parity and carry.

Each operation has its own rule for which flags it writes. Byte arithmetic writes all five flags. Increment and decrement leave carry alone. Bitwise operations force carry low. Rotates, carry control and the 16-bit pair add touch carry only. Complement touches no flag. A two-step decimal correction turns the binary sum of two packed BCD bytes into a BCD result. The surrounding machine writes the result back to the accumulator, or for compare and the pair add, ignores it.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, res_o and pair_o read 0 and flags_o reads 02h.
- R2: Outputs are registered. The inputs present at a rising edge give res_o, flags_o and pair_o after that edge. The op_i codes are 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 AND, 5 XOR, 6 OR, 7 CMP, 8 INC, 9 DEC, 10 RLC, 11 RRC, 12 RAL, 13 RAR, 14 DAA, 15 CMA, 16 STC, 17 CMC and 18 PADD. Any other code returns acc_i with the flags unchanged.
- R3: ADD and ADC return acc_i + opnd_i (+CY for ADC) mod 256. CY is the carry out of bit 7 and AC is the carry out of bit 3. S, Z and P follow the result.
- R4: SUB and SBB return acc_i - opnd_i (-CY for SBB) mod 256. CY is set on a borrow. AC is set when the low nibble of acc_i is less than the low nibble of opnd_i plus the borrow-in. S, Z and P follow the result.
- R5: INC and DEC return opnd_i + 1 and opnd_i - 1. AC is set when the low nibble carries (INC) or borrows (DEC). S, Z and P follow the result, and CY keeps its input value.
- R6: AND, XOR and OR combine acc_i with opnd_i bitwise. They clear CY and AC and set S, Z and P from the result.
- R7: CMP returns acc_i unchanged. It sets the flags exactly as SUB would: Z when the operands are equal, CY when acc_i < opnd_i.
- R8: RLC sends bit 7 to bit 0 and to CY. RRC sends bit 0 to bit 7 and to CY. RAL shifts left with the old CY entering bit 0 and bit 7 going to CY. RAR shifts right with the old CY entering bit 7 and bit 0 going to CY. No other flag changes.
- R9: CMA returns the bitwise inverse of acc_i with no flag changed. STC sets CY to 1 and CMC inverts CY. Both return acc_i and leave the other flags alone.
- R10: DAA adds 06h when the low nibble of acc_i exceeds 9 or AC is set, and sets AC to the carry out of bit 3 of that step (0 if the step is skipped). It then adds 60h to that value when its high nibble exceeds 9 or the input CY is set. CY becomes input CY OR the carry of step one OR whether step two ran. S, Z and P follow the result.
- R11: pair_o is hl_i + rp_i mod 65536 on every operation. For PADD, CY becomes the carry out of bit 15 and every other flag keeps its value (0127h + 2AB6h gives 2BDDh).
- R12: The flag byte has S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1. P is 1 for an even number of ones in the byte it describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Operation selector |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second byte operand |
| flags_i | input | 8 | Current flag byte |
| hl_i | input | 16 | Pointer pair for the 16-bit add |
| rp_i | input | 16 | Pair added to hl_i |
| res_o | output | 8 | Byte result |
| flags_o | output | 8 | Updated flag byte |
| pair_o | output | 16 | 16-bit pair sum |

## Verification
The add and subtract families are driven with operand pairs that produce a zero result, a carry or borrow from bit 7 alone, a carry or borrow from bit 3 alone, and both at once. This separates the carry and half-carry paths and catches inverted borrow sense. Increment and decrement are tried at FFh, 00h, 0Fh and 10h with both input carry values, to show that carry is preserved rather than recomputed. The decimal correction gets BCD sums that need no fix, only a low fix, only a high fix, both fixes, and a wrap from the low step, which separates the two steps. Random operands over every code, with random flag bytes that include the stuck bits, then test that the flags each operation must leave alone really stay unchanged.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  op_i,
  input  logic [7:0]  acc_i,
  input  logic [7:0]  opnd_i,
  input  logic [7:0]  flags_i,
  input  logic [15:0] hl_i,
  input  logic [15:0] rp_i,
  output logic [7:0]  res_o,
  output logic [7:0]  flags_o,
  output logic [15:0] pair_o
);
  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_DAA = 5'd14, OP_CMA = 5'd15,
    OP_STC = 5'd16, OP_CMC = 5'd17, OP_PADD = 5'd18
  } alu_op_e;

  logic        cy_in, ac_in, is_sub, use_cin, cin, ci;
  logic [7:0]  bx;
  logic [8:0]  sum9;
  logic [4:0]  low5;
  logic [16:0] pair17;
  logic        lo_adj, hi_adj;
  logic [8:0]  daa1;
  logic [7:0]  daa2;

  assign cy_in   = flags_i[0];
  assign ac_in   = flags_i[4];
  assign is_sub  = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_CMP);
  assign use_cin = (op_i == OP_ADC) || (op_i == OP_SBB);
  assign cin     = use_cin & cy_in;
  assign bx      = is_sub ? ~opnd_i : opnd_i;
  assign ci      = is_sub ? ~cin : cin;
  assign sum9    = {1'b0, acc_i} + {1'b0, bx} + {8'd0, ci};
  assign low5    = {1'b0, acc_i[3:0]} + {1'b0, bx[3:0]} + {4'd0, ci};
  assign pair17  = {1'b0, hl_i} + {1'b0, rp_i};

  assign lo_adj  = (acc_i[3:0] > 4'd9) || ac_in;
  assign daa1    = {1'b0, acc_i} + (lo_adj ? 9'h006 : 9'h000);
  assign hi_adj  = (daa1[7:4] > 4'd9) || cy_in;
  assign daa2    = daa1[7:0] + (hi_adj ? 8'h60 : 8'h00);

  logic [7:0] res_n, szp_src;
  logic       szp_upd, ac_n, cy_n;
  logic [4:0] inc_low;

  always_comb begin
    res_n   = acc_i;
    szp_src = acc_i;
    szp_upd = 1'b0;
    ac_n    = ac_in;
    cy_n    = cy_in;
    inc_low = 5'd0;
    case (op_i)
      OP_ADD, OP_ADC: begin
        res_n = sum9[7:0]; szp_src = sum9[7:0]; szp_upd = 1'b1;
        cy_n = sum9[8]; ac_n = low5[4];
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        if (op_i != OP_CMP) res_n = sum9[7:0];
        szp_src = sum9[7:0]; szp_upd = 1'b1;
        cy_n = ~sum9[8]; ac_n = ~low5[4];
      end
      OP_AND, OP_XOR, OP_OR: begin
        if (op_i == OP_AND)      res_n = acc_i & opnd_i;
        else if (op_i == OP_XOR) res_n = acc_i ^ opnd_i;
        else                     res_n = acc_i | opnd_i;
        szp_src = res_n; szp_upd = 1'b1; cy_n = 1'b0; ac_n = 1'b0;
      end
      OP_INC: begin
        res_n = opnd_i + 8'd1; szp_src = res_n; szp_upd = 1'b1;
        inc_low = {1'b0, opnd_i[3:0]} + 5'd1; ac_n = inc_low[4];
      end
      OP_DEC: begin
        res_n = opnd_i - 8'd1; szp_src = res_n; szp_upd = 1'b1;
        ac_n = (opnd_i[3:0] == 4'd0);
      end
      OP_RLC: begin res_n = {acc_i[6:0], acc_i[7]}; cy_n = acc_i[7]; end
      OP_RRC: begin res_n = {acc_i[0], acc_i[7:1]}; cy_n = acc_i[0]; end
      OP_RAL: begin res_n = {acc_i[6:0], cy_in};    cy_n = acc_i[7]; end
      OP_RAR: begin res_n = {cy_in, acc_i[7:1]};    cy_n = acc_i[0]; end
      OP_DAA: begin
        res_n = daa2; szp_src = daa2; szp_upd = 1'b1;
        inc_low = {1'b0, acc_i[3:0]} + 5'd6;
        ac_n = lo_adj & inc_low[4];
        cy_n = cy_in | daa1[8] | hi_adj;
      end
      OP_CMA:  res_n = ~acc_i;
      OP_STC:  cy_n = 1'b1;
      OP_CMC:  cy_n = ~cy_in;
      OP_PADD: cy_n = pair17[16];
      default: ;
    endcase
  end

  logic s_n, z_n, p_n;
  assign s_n = szp_upd ? szp_src[7] : flags_i[7];
  assign z_n = szp_upd ? (szp_src == 8'd0) : flags_i[6];
  assign p_n = szp_upd ? ~^szp_src : flags_i[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o   <= 8'd0;
      flags_o <= 8'h02;
      pair_o  <= 16'd0;
    end else begin
      res_o   <= res_n;
      flags_o <= {s_n, z_n, 1'b0, ac_n, 1'b0, p_n, 1'b1, cy_n};
      pair_o  <= pair17[15:0];
    end
  end

  p_fixed_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0) && (flags_o[1] == 1'b1));

  p_incdec_keep_cy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_INC || op_i == OP_DEC) |=> flags_o[0] == $past(flags_i[0]));

  p_logic_clear_cy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR) |=> (flags_o[0] == 1'b0) && (flags_o[4] == 1'b0));

  p_cmp_keeps_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |=> res_o == $past(acc_i));

  p_cma_no_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMA) |=> (flags_o & 8'hD5) == ($past(flags_i) & 8'hD5));

  p_stc_sets_cy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_STC) |=> flags_o[0] == 1'b1);

  p_padd_only_cy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PADD) |=> (flags_o[7:1] & 7'h6A) == ($past(flags_i[7:1]) & 7'h6A));
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op_i = '0;
  logic [7:0]  acc_i = '0, opnd_i = '0, flags_i = 8'h02;
  logic [15:0] hl_i = '0, rp_i = '0;
  logic [7:0]  res_o, flags_o;
  logic [15:0] pair_o;

  int vectors = 0;
  int misses  = 0;

  acc_alu dut (.clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
               .flags_i(flags_i), .hl_i(hl_i), .rp_i(rp_i),
               .res_o(res_o), .flags_o(flags_o), .pair_o(pair_o));

  always #5 clk = ~clk;

  function automatic int par_even(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0, 1:             return "R3";
      2, 3:             return "R4";
      4, 5, 6:          return "R6";
      7:                return "R7";
      8, 9:             return "R5";
      10, 11, 12, 13:   return "R8";
      14:               return "R10";
      15, 16, 17:       return "R9";
      18:               return "R11";
      default:          return "R2";
    endcase
  endfunction

  // reference: returns {pair, flags, res}
  function automatic logic [31:0] model(input int op, input int a, input int b, input int f,
                                        input int hl, input int rp);
    int s = (f >> 7) & 1, z = (f >> 6) & 1, ac = (f >> 4) & 1, p = (f >> 2) & 1, cy = f & 1;
    int r = a, t, c, lo, stepc, hiadj, full = 0, src;
    case (op)
      0, 1: begin
        c = (op == 1) ? cy : 0;
        t = a + b + c; cy = (t > 255); ac = ((a & 15) + (b & 15) + c) > 15;
        r = t & 255; src = r; full = 1;
      end
      2, 3, 7: begin
        c = (op == 3) ? cy : 0;
        t = a - b - c; cy = (t < 0); ac = (a & 15) < ((b & 15) + c);
        src = t & 255; full = 1; r = (op == 7) ? a : src;
      end
      4, 5, 6: begin
        r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
        src = r; full = 1; cy = 0; ac = 0;
      end
      8: begin r = (b + 1) & 255; ac = ((b & 15) == 15); src = r; full = 1; end
      9: begin r = (b + 255) & 255; ac = ((b & 15) == 0); src = r; full = 1; end
      10: begin r = ((a << 1) | (a >> 7)) & 255; cy = a >> 7; end
      11: begin r = (a >> 1) | ((a & 1) << 7); cy = a & 1; end
      12: begin r = ((a << 1) | cy) & 255; cy = a >> 7; end
      13: begin r = (a >> 1) | (cy << 7); cy = a & 1; end
      14: begin
        lo = a & 15; t = a; stepc = 0; hiadj = 0;
        if (lo > 9 || ac == 1) begin ac = (lo + 6) > 15; t = a + 6; end
        else ac = 0;
        if (t > 255) stepc = 1;
        t = t & 255;
        if (((t >> 4) > 9) || cy == 1) begin t = t + 16'h60; hiadj = 1; end
        cy = cy | stepc | hiadj; r = t & 255; src = r; full = 1;
      end
      15: r = (~a) & 255;
      16: cy = 1;
      17: cy = 1 - cy;
      18: cy = ((hl + rp) > 65535);
      default: ;
    endcase
    if (full == 1) begin s = (src >> 7) & 1; z = (src == 0); p = par_even(src); end
    t = (s << 7) | (z << 6) | (ac << 4) | (p << 2) | 2 | cy;
    model = {16'((hl + rp) & 65535), 8'(t), 8'(r)};
  endfunction

  logic [31:0] exp_q;
  int          exp_op;
  bit          pending = 0;

  task automatic compare();
    if (pending) begin
      vectors++;
      if ({pair_o, flags_o, res_o} !== exp_q) begin
        misses++;
        $display("FAIL %s op=%0d: res=%02h flags=%02h pair=%04h, expected res=%02h flags=%02h pair=%04h",
                 req_of(exp_op), exp_op, res_o, flags_o, pair_o, exp_q[7:0], exp_q[15:8], exp_q[31:16]);
      end
    end
  endtask

  task automatic apply(input int op, input int a, input int b, input int f,
                       input int hl = 0, input int rp = 0);
    @(negedge clk);
    compare();
    op_i = 5'(op); acc_i = 8'(a); opnd_i = 8'(b); flags_i = 8'(f);
    hl_i = 16'(hl); rp_i = 16'(rp);
    exp_q = model(op, a, b, f, hl, rp); exp_op = op; pending = 1;
  endtask

  task automatic chk_reset(input string tag);
    vectors++;
    if (res_o !== 8'd0 || flags_o !== 8'h02 || pair_o !== 16'd0) begin
      misses++;
      $display("FAIL %s reset: res=%02h flags=%02h pair=%04h, expected 00 02 0000",
               tag, res_o, flags_o, pair_o);
    end
  endtask

  initial begin
    #200000;
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    op_i = 5'd0; acc_i = 8'h55; opnd_i = 8'hAA; hl_i = 16'h1234; rp_i = 16'h1111;
    repeat (3) @(posedge clk);
    @(negedge clk); chk_reset("R1");
    rst_n = 1'b1;
    op_i = 5'd0; acc_i = 8'h00; opnd_i = 8'h00; flags_i = 8'h02; hl_i = '0; rp_i = '0;
    // R3 add corner cases
    apply(0, 8'hAF, 8'hB5, 8'h02);
    apply(0, 8'h0F, 8'h01, 8'h02);
    apply(0, 8'h80, 8'h80, 8'h02);
    apply(1, 8'hA9, 8'hBD, 8'h03);
    apply(1, 8'hFF, 8'h00, 8'h03);
    apply(0, 8'h40, 8'h3A, 8'h02);
    // R4 subtract cases
    apply(2, 8'hAF, 8'hB5, 8'h02);
    apply(2, 8'h56, 8'h2C, 8'h02);
    apply(2, 8'h10, 8'h01, 8'h02);
    apply(3, 8'h00, 8'h00, 8'h03);
    apply(3, 8'hAF, 8'hB5, 8'h03);
    // R5 inc/dec with both carries
    apply(8, 8'h00, 8'hFF, 8'h02);
    apply(8, 8'h00, 8'h0F, 8'h03);
    apply(9, 8'h00, 8'h00, 8'h03);
    apply(9, 8'h00, 8'h10, 8'h02);
    // R6 logic
    apply(4, 8'h73, 8'hC3, 8'h13);
    apply(5, 8'h73, 8'hC3, 8'h13);
    apply(6, 8'h73, 8'hC3, 8'h13);
    apply(5, 8'h5A, 8'h5A, 8'h03);
    // R7 compare
    apply(7, 8'h09, 8'h09, 8'h03);
    apply(7, 8'h08, 8'h09, 8'h02);
    apply(7, 8'h0A, 8'h09, 8'h03);
    // R8 rotates
    apply(10, 8'h81, 8'h00, 8'hD6);
    apply(11, 8'h01, 8'h00, 8'hD6);
    apply(12, 8'h80, 8'h00, 8'h03);
    apply(13, 8'h01, 8'h00, 8'h02);
    // R9 complement and carry control
    apply(15, 8'h0B, 8'h00, 8'hD7);
    apply(16, 8'h12, 8'h00, 8'h46);
    apply(17, 8'h12, 8'h00, 8'h47);
    // R10 decimal adjust
    apply(14, 8'h12, 8'h00, 8'h02);
    apply(14, 8'h1C, 8'h00, 8'h02);
    apply(14, 8'hA2, 8'h00, 8'h02);
    apply(14, 8'h9A, 8'h00, 8'h02);
    apply(14, 8'h00, 8'h00, 8'h13);
    apply(14, 8'hFA, 8'h00, 8'h02);
    // R11 pair add
    apply(18, 8'h33, 8'h00, 8'hD6, 16'h0127, 16'h2AB6);
    apply(18, 8'h33, 8'h00, 8'h02, 16'hFFFF, 16'h0001);
    // R2 unused code and R12 stuck bits from dirty flag bytes
    apply(25, 8'h44, 8'h00, 8'hFF);
    apply(31, 8'h44, 8'h00, 8'h00);
    // random sweep over all codes (R2..R12)
    for (int k = 0; k < 1500; k++)
      apply(int'($urandom_range(0, 19)), int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)));
    @(negedge clk); compare(); pending = 0;
    // R1 reset re-entry
    rst_n = 1'b0;
    @(negedge clk); chk_reset("R1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule